// File: doc/BRIEF.md
# Serial-Bus UART Bridge

This block is a slave on a four-wire serial expansion bus. A host uses it to feed a UART transmitter. The host pulls the chip select low and shifts in a 32-bit command word. It then keeps clocking to either read a response or stream payload bytes, and it ends the command by releasing the select. Payload bytes land in a small transmit queue. A plain 8N1 transmitter empties that queue onto a single serial line.

The host never writes to a register to learn the fill level of the queue. It issues a status command, and the bridge answers with one byte that holds the occupancy and a sticky drop flag. The host can also fetch a fixed revision word. It can read a fixed identification word by shifting 16 zero bits and then reading 32 bits. All bus pins are oversampled by the system clock, so every bus event is seen a few system cycles after it happens on the pins.

Top module: `uart_bridge`

## Requirements
- R1: After reset, `uart_txd` is high, `bus_miso` is low, the queue is empty and the drop flag is clear, so a status read returns 0x00.
- R2: `bus_cs_n` is active low and `bus_sck` idles low. The bridge samples `bus_mosi` on each rising `bus_sck` edge, most significant bit first. `bus_miso` changes only after a rising edge and holds until the next rising edge.
- R3: The command 0x20010000 makes the next 8 bits on `bus_miso` a status byte. Bit 7 is the drop flag and bits 6:0 give the number of bytes waiting in the queue.
- R4: After the command 0xA0010000, every complete byte that is shifted in during the same select window is appended to the queue.
- R5: The queue holds FIFO_DEPTH bytes (16 by default). A byte leaves the occupancy count once the transmitter takes it.
- R6: A byte that arrives while the queue holds 16 bytes is dropped and sets the drop flag. The flag clears once a full status byte has been shifted out.
- R7: The command 0x20011300 makes the next 32 bits on `bus_miso` the revision word, which is 0x00020103 by default.
- R8: If the first 16 bits of a selection are all zero, the next 32 bits on `bus_miso` are the identification word, which is 0x0A050000 by default.
- R9: Any other command keeps `bus_miso` low for the rest of the window and queues nothing.
- R10: Releasing `bus_cs_n` ends the current command and discards any partial byte. The next selection starts with a new command word.
- R11: `uart_txd` sends each byte as one low start bit, eight data bits least significant bit first and one high stop bit, each lasting CLKS_PER_BIT cycles. Bytes go out in queue order, and the line idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Bus select, active low |
| bus_sck | input | 1 | Bus bit clock, idle low |
| bus_mosi | input | 1 | Host-to-bridge serial data |
| bus_miso | output | 1 | Bridge-to-host serial data |
| uart_txd | output | 1 | UART transmit line |

## Verification
A pin change on the bus takes effect in the decoder about three system cycles later, after two synchroniser stages and one registered stage. `bus_miso` settles within four cycles of a rising `bus_sck` edge. The bench holds each `bus_sck` half period for eight system cycles and samples `bus_miso` on the last falling system-clock edge before it raises `bus_sck`. A queued byte reaches the line within three cycles when the transmitter is idle. The bench receiver locks onto the falling start edge and samples the middle of each bit. The baud divisor is large in the bench so that queue occupancy stays fixed while status is read back.

// File: rtl/ub_pkg.sv
package ub_pkg;
  localparam int CMD_BITS = 32;
  localparam int ID_LEAD_BITS = 16;
  localparam int BYTE_W = 8;

  localparam logic [CMD_BITS-1:0] CMD_STATUS = 32'h2001_0000;
  localparam logic [CMD_BITS-1:0] CMD_WRITE  = 32'hA001_0000;
  localparam logic [CMD_BITS-1:0] CMD_REV    = 32'h2001_1300;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_STAT,
    ST_WR,
    ST_RESP,
    ST_IGN
  } ub_state_e;
endpackage

// File: rtl/ub_pin_sync.sv
module ub_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sel,
  output logic mosi_s
);
  logic [2:0] sck_q;
  logic [1:0] cs_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      cs_q   <= {cs_q[0], cs_n_i};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sel      = ~cs_q[1];
  assign mosi_s   = mosi_q[1];
endmodule

// File: rtl/ub_txq.sv
module ub_txq #(
  parameter int DEPTH = 16,
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rdata <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> $stable(count));
endmodule

// File: rtl/ub_uart_tx.sv
module ub_uart_tx #(
  parameter int CLKS_PER_BIT = 434,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] data,
  output logic         busy,
  output logic         txd
);
  localparam int DW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int BW = $clog2(W+2);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLKS_PER_BIT-1);
  localparam logic [BW-1:0] SLOT_LAST = BW'(W+1);

  logic [W:0]    frame;
  logic [DW-1:0] div;
  logic [BW-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= '1;
      div   <= '0;
      slot  <= '0;
      busy  <= 1'b0;
      txd   <= 1'b1;
    end else if (!busy) begin
      txd <= 1'b1;
      if (load) begin
        frame <= {1'b1, data};
        div   <= '0;
        slot  <= '0;
        busy  <= 1'b1;
        txd   <= 1'b0;
      end
    end else if (div == DIV_LAST) begin
      div <= '0;
      if (slot == SLOT_LAST) begin
        busy <= 1'b0;
        txd  <= 1'b1;
      end else begin
        txd   <= frame[0];
        frame <= {1'b1, frame[W:1]};
        slot  <= slot + 1'b1;
      end
    end else begin
      div <= div + 1'b1;
    end
  end

  a_r11_load_when_idle: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy);
  a_r11_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(load)) |-> txd);
endmodule

// File: rtl/uart_bridge.sv
module uart_bridge #(
  parameter int          FIFO_DEPTH   = 16,
  parameter int          CLKS_PER_BIT = 434,
  parameter logic [31:0] REV_WORD     = 32'h0002_0103,
  parameter logic [31:0] ID_WORD      = 32'h0A05_0000
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_cs_n,
  input  logic bus_sck,
  input  logic bus_mosi,
  output logic bus_miso,
  output logic uart_txd
);
  import ub_pkg::*;

  localparam int CW  = $clog2(FIFO_DEPTH+1);
  localparam int BCW = $clog2(CMD_BITS);
  localparam logic [BCW-1:0] CMD_LAST  = BCW'(CMD_BITS-1);
  localparam logic [BCW-1:0] ID_LAST   = BCW'(ID_LEAD_BITS-1);
  localparam logic [BCW-1:0] BYTE_LAST = BCW'(BYTE_W-1);

  logic                sck_rise, sel, mosi_s;
  ub_state_e           state;
  logic [BCW-1:0]      bit_cnt;
  logic [CMD_BITS-1:0] in_sr, in_next, resp_sr;
  logic                push, clr_ovf, ovf;
  logic [BYTE_W-1:0]   push_data, q_rdata;
  logic [CW-1:0]       q_count;
  logic                q_full, q_empty;
  logic                pop, pend, tx_busy;
  logic [BYTE_W-1:0]   status_byte;

  ub_pin_sync u_sync (
    .clk(clk), .rst(rst), .sck_i(bus_sck), .cs_n_i(bus_cs_n), .mosi_i(bus_mosi),
    .sck_rise(sck_rise), .sel(sel), .mosi_s(mosi_s)
  );

  assign in_next     = {in_sr[CMD_BITS-2:0], mosi_s};
  assign status_byte = {ovf, 7'(q_count)};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CMD;
      bit_cnt   <= '0;
      in_sr     <= '0;
      resp_sr   <= '0;
      push      <= 1'b0;
      push_data <= '0;
      clr_ovf   <= 1'b0;
    end else begin
      push    <= 1'b0;
      clr_ovf <= 1'b0;
      if (!sel) begin
        state   <= ST_CMD;
        bit_cnt <= '0;
        in_sr   <= '0;
        resp_sr <= '0;
      end else if (sck_rise) begin
        unique case (state)
          ST_CMD: begin
            in_sr   <= in_next;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == ID_LAST && in_next[ID_LEAD_BITS-1:0] == '0) begin
              state   <= ST_RESP;
              resp_sr <= ID_WORD;
              bit_cnt <= '0;
            end else if (bit_cnt == CMD_LAST) begin
              bit_cnt <= '0;
              in_sr   <= '0;
              case (in_next)
                CMD_STATUS: begin
                  state   <= ST_STAT;
                  resp_sr <= {status_byte, {(CMD_BITS-BYTE_W){1'b0}}};
                end
                CMD_WRITE: state <= ST_WR;
                CMD_REV: begin
                  state   <= ST_RESP;
                  resp_sr <= REV_WORD;
                end
                default: state <= ST_IGN;
              endcase
            end
          end
          ST_STAT: begin
            resp_sr <= {resp_sr[CMD_BITS-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BYTE_LAST) begin
              state   <= ST_IGN;
              clr_ovf <= 1'b1;
            end
          end
          ST_WR: begin
            in_sr <= in_next;
            if (bit_cnt == BYTE_LAST) begin
              bit_cnt   <= '0;
              push      <= 1'b1;
              push_data <= in_next[BYTE_W-1:0];
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_RESP: resp_sr <= {resp_sr[CMD_BITS-2:0], 1'b0};
          ST_IGN:  resp_sr <= '0;
        endcase
      end
    end
  end

  assign bus_miso = resp_sr[CMD_BITS-1];

  always_ff @(posedge clk) begin
    if (rst)                 ovf <= 1'b0;
    else if (push && q_full) ovf <= 1'b1;
    else if (clr_ovf)        ovf <= 1'b0;
  end

  ub_txq #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_txq (
    .clk(clk), .rst(rst), .push(push), .wdata(push_data), .pop(pop),
    .rdata(q_rdata), .count(q_count), .full(q_full), .empty(q_empty)
  );

  assign pop = ~tx_busy & ~pend & ~q_empty;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= pop;
  end

  ub_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .W(BYTE_W)) u_tx (
    .clk(clk), .rst(rst), .load(pend), .data(q_rdata), .busy(tx_busy), .txd(uart_txd)
  );

  a_r6_flag_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(push && q_full));
  a_r10_release_quiet: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !bus_miso);
  a_r9_unknown_no_push: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGN) |=> !push);
endmodule

// File: tb/uart_bridge_bench.sv
module uart_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SCK_HALF   = 8;
  localparam int CPB        = 400;
  localparam int WDOG       = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, txd;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] rx_log [64];
  int rx_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_bridge #(.CLKS_PER_BIT(CPB)) u_uart_bridge (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_sck(sck), .bus_mosi(mosi),
    .bus_miso(miso), .uart_txd(txd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // UART receiver, R11: start low, 8 bits LSB first, stop high
  initial begin
    forever begin
      logic [7:0] b;
      @(negedge txd);
      repeat (CPB/2) @(posedge clk);
      if (!rst) begin
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(posedge clk);
          b[i] = txd;
        end
        repeat (CPB) @(posedge clk);
        chk("R11 stop bit", {31'd0, txd}, 32'd1);
        if (rx_n < 64) rx_log[rx_n] = b;
        rx_n++;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_byte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      wait_clk(SCK_HALF);
      r[i] = miso;
      sck = 1'b1;
      wait_clk(SCK_HALF);
      sck = 1'b0;
    end
  endtask

  task automatic bus_bits(input int n);
    for (int i = 0; i < n; i++) begin
      mosi = 1'b1;
      wait_clk(SCK_HALF);
      sck = 1'b1;
      wait_clk(SCK_HALF);
      sck = 1'b0;
    end
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    wait_clk(SCK_HALF);
  endtask

  task automatic sel_off();
    wait_clk(SCK_HALF);
    cs_n = 1'b1;
    wait_clk(2*SCK_HALF);
  endtask

  task automatic send_word(input logic [31:0] w);
    logic [7:0] r;
    for (int k = 3; k >= 0; k--) bus_byte(w[k*8 +: 8], r);
  endtask

  task automatic read_word(output logic [31:0] w);
    logic [7:0] r;
    for (int k = 3; k >= 0; k--) begin
      bus_byte(8'h00, r);
      w[k*8 +: 8] = r;
    end
  endtask

  task automatic read_status(output logic [7:0] s);
    sel_on();
    send_word(32'h2001_0000);
    bus_byte(8'h00, s);
    sel_off();
  endtask

  task automatic wait_rx(input int n, input string req);
    int t = 0;
    while (rx_n < n && t < 100000) begin
      wait_clk(1);
      t++;
    end
    wait_clk(CPB*12);
    chk(req, rx_n, n);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 txd idle high", {31'd0, txd}, 32'd1);
    chk("R1 miso low", {31'd0, miso}, 32'd0);
    read_status(s);
    chk("R1 R3 status after reset", {24'd0, s}, 32'h00);
  endtask

  task automatic t_rev();
    logic [31:0] w;
    sel_on();
    send_word(32'h2001_1300);
    read_word(w);
    sel_off();
    chk("R7 R2 revision word", w, 32'h0002_0103);
  endtask

  task automatic t_id();
    logic [7:0] r;
    logic [31:0] w;
    sel_on();
    bus_byte(8'h00, r);
    bus_byte(8'h00, r);
    read_word(w);
    sel_off();
    chk("R8 identification word", w, 32'h0A05_0000);
  endtask

  task automatic t_unknown();
    logic [7:0] r, s;
    sel_on();
    send_word(32'h1234_5678);
    bus_byte(8'hFF, r);
    sel_off();
    chk("R9 miso low after unknown command", {24'd0, r}, 32'h00);
    read_status(s);
    chk("R9 nothing queued", {24'd0, s}, 32'h00);
    chk("R9 nothing transmitted", rx_n, 0);
  endtask

  task automatic t_write();
    logic [7:0] r, s;
    int base = rx_n;
    sel_on();
    send_word(32'hA001_0000);
    bus_byte(8'hA1, r);
    bus_byte(8'hA2, r);
    bus_byte(8'hA3, r);
    bus_byte(8'hA4, r);
    sel_off();
    read_status(s);
    chk("R4 R5 occupancy after 4 bytes, one in transmitter", {24'd0, s}, 32'h03);
    wait_rx(base + 4, "R11 four bytes on line");
    for (int i = 0; i < 4; i++)
      chk("R11 byte order and value", {24'd0, rx_log[base+i]}, 32'hA1 + i);
    read_status(s);
    chk("R5 queue empty after drain", {24'd0, s}, 32'h00);
  endtask

  task automatic t_partial();
    logic [7:0] r, s;
    int base = rx_n;
    sel_on();
    send_word(32'hA001_0000);
    bus_byte(8'hB0, r);
    bus_byte(8'hB1, r);
    bus_bits(5);
    sel_off();
    read_status(s);
    chk("R10 partial byte discarded, new command decoded", {24'd0, s}, 32'h01);
    wait_rx(base + 2, "R10 only whole bytes sent");
    chk("R10 first byte", {24'd0, rx_log[base]}, 32'hB0);
    chk("R10 second byte", {24'd0, rx_log[base+1]}, 32'hB1);
  endtask

  task automatic t_overflow();
    logic [7:0] r, s;
    int base = rx_n;
    sel_on();
    send_word(32'hA001_0000);
    for (int i = 0; i < 19; i++) bus_byte(8'h40 + 8'(i), r);
    sel_off();
    read_status(s);
    chk("R6 R3 full queue with drop flag", {24'd0, s}, 32'h90);
    read_status(s);
    chk("R6 drop flag cleared by status read", {31'd0, s[7]}, 32'd0);
    wait_rx(base + 17, "R6 dropped bytes never sent");
    for (int i = 0; i < 17; i++)
      chk("R5 R11 overflow run order", {24'd0, rx_log[base+i]}, 32'h40 + i);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_rev();
    t_id();
    t_unknown();
    t_write();
    t_partial();
    t_overflow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule